// File: doc/BRIEF.md
# Fully Associative Translation Cache

This block keeps a handful of recently used page translations so that most address translations avoid a page table walk. Every slot holds a valid flag, an address-space identifier, a 20-bit virtual page number and a 20-bit physical frame number. Any translation may sit in any slot. A lookup compares a page number and the current address-space identifier against every slot at once. Hit and frame appear one cycle after the request.

The walker installs a translation it has just resolved through the fill port. A fill takes a free slot while one exists. When every slot is valid, the fill replaces the least recently used slot, and both lookup hits and fills count as use. Because every slot carries an address-space identifier, a process switch needs no flush. The maintenance inputs remove one page from every address space, or clear the whole cache in a single cycle.

Top module: `xlate_cache`

## Requirements
- R1: After reset every slot is invalid, `lk_hit` is 0, and a lookup of any page misses.
- R2: A lookup presented in cycle t drives `lk_hit` and `lk_pfn` in cycle t+1. On a miss, or with no lookup, `lk_hit` is 0 and `lk_pfn` is 0.
- R3: A hit needs both the page number and the address-space identifier to equal those of a valid slot. The same page may be cached under two identifiers with different frames.
- R4: While any slot is invalid, a fill of a new translation takes an invalid slot and displaces no valid translation. After four distinct fills into an empty cache, all four hit.
- R5: With all slots valid, a fill of a new translation replaces the slot whose last use is oldest. A use is a fill or a lookup hit.
- R6: A lookup hit makes the hit slot the most recently used one.
- R7: A fill whose page and identifier are already cached overwrites that slot's frame and evicts nothing else.
- R8: A page invalidate clears every slot holding that page number, whatever its identifier, and leaves the other slots intact.
- R9: A flush clears every slot in one cycle. Lookups from the next cycle on miss.
- R10: A fill asserted in the same cycle as a page invalidate or a flush is ignored.
- R11: A slot freed by a page invalidate in a full cache is reused by the next fill, and the other slots survive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Page number to translate |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_hit | output | 1 | Registered hit, one cycle after the request |
| lk_pfn | output | PFN_W | Registered frame of the hit, 0 on a miss |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page number to install |
| fill_asid | input | ASID_W | Identifier to install |
| fill_pfn | input | PFN_W | Frame to install |
| inv_valid | input | 1 | Invalidate one page in all address spaces |
| inv_vpn | input | VPN_W | Page to invalidate |
| flush_all | input | 1 | Clear every slot |

## Verification
Replacement order is the hardest thing to reach from the ports. Only an eviction reveals which slot was least recent, and that ranking depends on the whole history of fills and hits. The stimulus therefore fills the cache and then touches chosen slots with lookups, so that the slot expected to be evicted differs from the one a fill-order policy would pick. It then fills again and probes which page is gone. Duplicate fills, the same page under two identifiers, and invalidates in a full cache are placed in that same tracked history, so each expected eviction can be worked out by hand.

// File: rtl/xc_pkg.sv
package xc_pkg;
  typedef enum logic [1:0] {
    XC_OP_IDLE  = 2'd0,
    XC_OP_FILL  = 2'd1,
    XC_OP_INV   = 2'd2,
    XC_OP_FLUSH = 2'd3
  } xc_op_e;

  // Maintenance priority: flush over page invalidate over fill.
  function automatic xc_op_e xc_decode(input logic flush, input logic inv, input logic fill);
    if (flush)     return XC_OP_FLUSH;
    else if (inv)  return XC_OP_INV;
    else if (fill) return XC_OP_FILL;
    else           return XC_OP_IDLE;
  endfunction
endpackage

// File: rtl/xc_cam.sv
module xc_cam #(
  parameter int N         = 4,
  parameter int VPN_W     = 20,
  parameter int ASID_W    = 8,
  parameter bit MATCH_TAG = 1'b1
) (
  input  logic [N-1:0]             valid,
  input  logic [N-1:0][VPN_W-1:0]  vpn,
  input  logic [N-1:0][ASID_W-1:0] asid,
  input  logic [VPN_W-1:0]         key_vpn,
  input  logic [ASID_W-1:0]        key_asid,
  output logic [N-1:0]             match
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic tag_eq;
    assign tag_eq   = (asid[i] == key_asid) | ~MATCH_TAG;
    assign match[i] = valid[i] & (vpn[i] == key_vpn) & tag_eq;
  end
endmodule

// File: rtl/xc_lru.sv
module xc_lru #(
  parameter int N     = 4,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] lru_idx
);
  // rank 0 = most recent, rank N-1 = least recent; ranks form a permutation
  logic [N-1:0][IDX_W-1:0] rank_q;
  logic [N-1:0]            oldest_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) rank_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == touch_idx)           rank_q[i] <= '0;
        else if (rank_q[i] < rank_q[touch_idx]) rank_q[i] <= rank_q[i] + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_old
    assign oldest_vec[i] = (rank_q[i] == IDX_W'(N - 1));
  end

  always_comb begin
    lru_idx = '0;
    for (int i = 0; i < N; i++) if (oldest_vec[i]) lru_idx = IDX_W'(i);
  end

  // R5: exactly one slot holds the oldest rank at all times
  a_r5_one_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(oldest_vec));

  // R6: a touched slot is never the oldest in the following cycle (N > 1)
  a_r6_touch_not_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (lru_idx != $past(touch_idx)));
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache #(
  parameter int N      = 4,
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              inv_valid,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic              flush_all
);
  import xc_pkg::*;

  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]             valid_q;
  logic [N-1:0][VPN_W-1:0]  vpn_q;
  logic [N-1:0][ASID_W-1:0] asid_q;
  logic [N-1:0][PFN_W-1:0]  pfn_q;

  // Named internal events
  logic [N-1:0]     lk_match, dup_match, inv_match;
  logic             lk_any, dup_any, cache_full, fill_do;
  logic [IDX_W-1:0] lk_idx, fill_idx, lru_idx, touch_idx;
  logic             touch_en;
  logic [PFN_W-1:0] lk_pfn_sel;
  xc_op_e           op;

  function automatic logic [IDX_W-1:0] f_encode(input logic [N-1:0] v);
    logic [IDX_W-1:0] r = '0;
    for (int i = 0; i < N; i++) if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] f_lowest(input logic [N-1:0] v);
    logic [IDX_W-1:0] r = '0;
    for (int i = N - 1; i >= 0; i--) if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  xc_cam #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .MATCH_TAG(1'b1)) u_cam_lk (
    .valid(valid_q), .vpn(vpn_q), .asid(asid_q),
    .key_vpn(lk_vpn), .key_asid(lk_asid), .match(lk_match));

  xc_cam #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .MATCH_TAG(1'b1)) u_cam_dup (
    .valid(valid_q), .vpn(vpn_q), .asid(asid_q),
    .key_vpn(fill_vpn), .key_asid(fill_asid), .match(dup_match));

  xc_cam #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .MATCH_TAG(1'b0)) u_cam_inv (
    .valid(valid_q), .vpn(vpn_q), .asid(asid_q),
    .key_vpn(inv_vpn), .key_asid(lk_asid), .match(inv_match));

  xc_lru #(.N(N), .IDX_W(IDX_W)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en),
    .touch_idx(touch_idx), .lru_idx(lru_idx));

  assign op         = xc_decode(flush_all, inv_valid, fill_valid);
  assign fill_do    = (op == XC_OP_FILL);
  assign lk_any     = |lk_match;
  assign dup_any    = |dup_match;
  assign cache_full = &valid_q;
  assign lk_idx     = f_encode(lk_match);

  always_comb begin
    if (dup_any)          fill_idx = f_encode(dup_match);
    else if (!cache_full) fill_idx = f_lowest(~valid_q);
    else                  fill_idx = lru_idx;
  end

  always_comb begin
    lk_pfn_sel = '0;
    for (int i = 0; i < N; i++) if (lk_match[i]) lk_pfn_sel = lk_pfn_sel | pfn_q[i];
  end

  assign touch_en  = fill_do | (lk_valid & lk_any);
  assign touch_idx = fill_do ? fill_idx : lk_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      vpn_q   <= '0;
      asid_q  <= '0;
      pfn_q   <= '0;
    end else begin
      case (op)
        XC_OP_FLUSH: valid_q <= '0;
        XC_OP_INV:   valid_q <= valid_q & ~inv_match;
        XC_OP_FILL: begin
          valid_q[fill_idx] <= 1'b1;
          vpn_q[fill_idx]   <= fill_vpn;
          asid_q[fill_idx]  <= fill_asid;
          pfn_q[fill_idx]   <= fill_pfn;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_hit <= 1'b0;
      lk_pfn <= '0;
    end else begin
      lk_hit <= lk_valid & lk_any;
      lk_pfn <= (lk_valid & lk_any) ? lk_pfn_sel : '0;
    end
  end

  // R7: no two slots ever hold the same page and identifier
  a_r7_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  // R9: a flush leaves no valid slot
  a_r9_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_q == '0));

  // R2: no request, no hit in the next cycle
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!lk_hit && lk_pfn == '0));

  // R4: a new translation into a non-full cache adds one valid slot
  a_r4_grow_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_do && !cache_full && !dup_any) |=>
      ($countones(valid_q) == $countones($past(valid_q)) + 1));

  // R10: a fill beside a page invalidate never adds a slot
  a_r10_fill_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && inv_valid) |=>
      ($countones(valid_q) <= $countones($past(valid_q))));
endmodule

// File: tb/tb_xlate_cache.sv
`timescale 1ns/1ps
module tb_xlate_cache;
  localparam logic [7:0] TA = 8'h01;
  localparam logic [7:0] TB = 8'h02;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_hit;
  logic [19:0] lk_pfn;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [7:0]  fill_asid = '0;
  logic [19:0] fill_pfn = '0;
  logic        inv_valid = 1'b0;
  logic [19:0] inv_vpn = '0;
  logic        flush_all = 1'b0;

  int tests = 0;
  int fails = 0;
  logic [20:0] exp_q[$];
  string       req_q[$];

  always #4 clk = ~clk;

  xlate_cache dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_hit(lk_hit), .lk_pfn(lk_pfn),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_pfn(fill_pfn),
    .inv_valid(inv_valid), .inv_vpn(inv_vpn), .flush_all(flush_all));

  task automatic check(input string req, input logic [20:0] act, input logic [20:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got hit=%0b pfn=%05h, expected hit=%0b pfn=%05h",
               req, act[20], act[19:0], exp[20], exp[19:0]);
    end
  endtask

  // Driver: one lookup per cycle, expected result pushed to the scoreboard
  task automatic lookup(input logic [19:0] v, input logic [7:0] t,
                        input bit hit, input logic [19:0] pfn, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = v; lk_asid = t;
    exp_q.push_back({hit, hit ? pfn : 20'h0});
    req_q.push_back(req);
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic fill(input logic [19:0] v, input logic [7:0] t, input logic [19:0] p,
                      input bit with_inv, input bit with_flush);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = v; fill_asid = t; fill_pfn = p;
    inv_valid = with_inv; inv_vpn = 20'h00999; flush_all = with_flush;
    @(negedge clk);
    fill_valid = 1'b0; inv_valid = 1'b0; flush_all = 1'b0;
  endtask

  task automatic inval(input logic [19:0] v);
    @(negedge clk);
    inv_valid = 1'b1; inv_vpn = v;
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  // Monitor: a request sampled at an edge is checked just after that edge
  always @(posedge clk) begin
    if (rst_n && lk_valid) begin
      #1;
      if (exp_q.size() == 0) begin
        check("R2 unexpected result", {lk_hit, lk_pfn}, 21'h0);
      end else begin
        check(req_q.pop_front(), {lk_hit, lk_pfn}, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset hit low", {lk_hit, lk_pfn}, 21'h0);
    lookup(20'h00003, TA, 0, 0, "R1 empty miss");

    fill(20'h00003, TA, 20'h00005, 0, 0);
    fill(20'h00007, TA, 20'h00009, 0, 0);
    lookup(20'h00003, TA, 1, 20'h00005, "R2 hit 3");
    lookup(20'h00007, TA, 1, 20'h00009, "R2 hit 7");
    lookup(20'h00003, TB, 0, 0, "R3 wrong id misses");
    lookup(20'h00004, TA, 0, 0, "R2 miss frame zero");

    fill(20'h00009, TA, 20'h00001, 0, 0);
    fill(20'h0000B, TA, 20'h00003, 0, 0);
    lookup(20'h00003, TA, 1, 20'h00005, "R4 all four 3");
    lookup(20'h00007, TA, 1, 20'h00009, "R4 all four 7");
    lookup(20'h00009, TA, 1, 20'h00001, "R4 all four 9");
    lookup(20'h0000B, TA, 1, 20'h00003, "R4 all four B");

    // oldest is 3; touching it makes 7 the oldest
    lookup(20'h00003, TA, 1, 20'h00005, "R6 touch 3");
    fill(20'h0000D, TA, 20'h0000A, 0, 0);
    lookup(20'h00007, TA, 0, 0, "R5 7 evicted");
    lookup(20'h00003, TA, 1, 20'h00005, "R6 3 kept");
    lookup(20'h0000D, TA, 1, 20'h0000A, "R5 D installed");
    // oldest now 9
    fill(20'h0000E, TA, 20'h00011, 0, 0);
    lookup(20'h00009, TA, 0, 0, "R5 9 evicted");
    lookup(20'h0000B, TA, 1, 20'h00003, "R5 B kept");

    // recency oldest first: 3, D, E, B
    fill(20'h0000D, TA, 20'h00022, 0, 0);
    lookup(20'h0000D, TA, 1, 20'h00022, "R7 frame replaced");
    lookup(20'h00003, TA, 1, 20'h00005, "R7 no eviction 3");
    lookup(20'h0000E, TA, 1, 20'h00011, "R7 no eviction E");
    lookup(20'h0000B, TA, 1, 20'h00003, "R7 no eviction B");

    // oldest is D; same page B under the second identifier
    fill(20'h0000B, TB, 20'h00044, 0, 0);
    lookup(20'h0000B, TA, 1, 20'h00003, "R3 B under first id");
    lookup(20'h0000B, TB, 1, 20'h00044, "R3 B under second id");
    lookup(20'h0000D, TA, 0, 0, "R5 D evicted");

    inval(20'h0000B);
    lookup(20'h0000B, TA, 0, 0, "R8 B first id gone");
    lookup(20'h0000B, TB, 0, 0, "R8 B second id gone");
    lookup(20'h00003, TA, 1, 20'h00005, "R8 3 intact");
    lookup(20'h0000E, TA, 1, 20'h00011, "R8 E intact");

    fill(20'h000F1, TA, 20'h00055, 0, 0);
    fill(20'h000F2, TA, 20'h00066, 0, 0);
    lookup(20'h00003, TA, 1, 20'h00005, "R4 free slots first 3");
    lookup(20'h0000E, TA, 1, 20'h00011, "R4 free slots first E");
    lookup(20'h000F1, TA, 1, 20'h00055, "R4 F1");
    lookup(20'h000F2, TA, 1, 20'h00066, "R4 F2");

    inval(20'h0000E);
    fill(20'h00300, TA, 20'h00088, 0, 0);
    lookup(20'h00003, TA, 1, 20'h00005, "R11 3 survives");
    lookup(20'h000F1, TA, 1, 20'h00055, "R11 F1 survives");
    lookup(20'h000F2, TA, 1, 20'h00066, "R11 F2 survives");
    lookup(20'h00300, TA, 1, 20'h00088, "R11 reused slot");
    lookup(20'h0000E, TA, 0, 0, "R11 E gone");

    fill(20'h00100, TA, 20'h00077, 1, 0);
    lookup(20'h00100, TA, 0, 0, "R10 fill with invalidate ignored");
    lookup(20'h00003, TA, 1, 20'h00005, "R10 3 not evicted");
    lookup(20'h000F1, TA, 1, 20'h00055, "R10 F1 not evicted");
    lookup(20'h000F2, TA, 1, 20'h00066, "R10 F2 not evicted");
    lookup(20'h00300, TA, 1, 20'h00088, "R10 300 not evicted");

    fill(20'h00200, TA, 20'h00099, 0, 1);
    lookup(20'h00200, TA, 0, 0, "R10 fill with flush ignored");
    lookup(20'h00003, TA, 0, 0, "R9 3 flushed");
    lookup(20'h000F1, TA, 0, 0, "R9 F1 flushed");
    lookup(20'h00300, TA, 0, 0, "R9 300 flushed");
    fill(20'h00003, TA, 20'h00005, 0, 0);
    lookup(20'h00003, TA, 1, 20'h00005, "R9 refill after flush");

    repeat (3) @(negedge clk);
    check("R2 scoreboard drained", {20'h0, exp_q.size() != 0}, 21'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule